// File: doc/BRIEF.md
# Pause Frame Builder with Frame Check Sequence

This block builds a complete flow-control pause frame after a one-cycle start command from the scheduler. It sends the frame one byte per beat on an AXI4-Stream-style master port (data, valid, ready, last). It has two formats. The global format carries one quanta value. The priority format carries a class-enable vector followed by one quanta slot per class. Destination address, source address, EtherType, opcode and quanta all come from configuration inputs. Each format has its own address, EtherType and opcode set.

The start command names the format, the set of classes being requested and the set of classes being cancelled. The block stores the command when it accepts it. It derives the enable vector from the union of requested and cancelled classes. A cancelled class keeps its enable bit but goes out with quanta zero. The block pads the frame with zeros to 60 bytes and then appends a 4-byte CRC-32. Preamble and link arbitration sit outside the block.

Top module: `pause_frame_tx`

## Requirements
- R1: While reset is held and after it is released, `busy`, `m_tvalid` and `m_tlast` are low until a start command is accepted.
- R2: A `go` pulse seen while `busy` is low is accepted. `busy` is high in the next cycle, and the frame that follows is exactly 64 bytes long with `m_tlast` high only on byte 63.
- R3: A `go` pulse while `busy` is high is ignored. The frame in progress keeps its format and contents, and no extra frame follows it.
- R4: A global frame (`go_global`=1) sends the global destination address on bytes 0-5, source address on 6-11, EtherType on 12-13, opcode on 14-15 and quanta on 16-17, each field most significant byte first.
- R5: A priority frame (`go_global`=0) sends the priority address, EtherType and opcode set in the same header positions. Bytes 16-17 carry the enable vector, with class c in bit c of byte 17 and byte 16 zero. Bytes 18-33 carry the quanta of classes 0 to 7 in order, two bytes each, most significant byte first. The enable vector is `go_classes | go_cancel[7:0]`.
- R6: A class with its `go_cancel` bit set is sent with quanta 0 while its enable bit stays set. `go_cancel[8]` sends a global frame with quanta 0. Quanta slots of classes outside the enable vector are 0.
- R7: Every byte after the last field, up to and including byte 59, is zero.
- R8: Bytes 60-63 carry the CRC-32 of bytes 0-59, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an initial value of all ones and an inverted result.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values into the next cycle.
- R10: `busy` falls in the cycle after byte 63 is accepted. A `go` in that same cycle is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start command, one-cycle pulse |
| go_global | input | 1 | 1 selects the global format, 0 the priority format |
| go_classes | input | 8 | Classes requested with their configured quanta |
| go_cancel | input | 9 | Classes 0-7 (bits 7:0) and global (bit 8) sent with zero quanta |
| busy | output | 1 | High from an accepted command until the last byte is accepted |
| g_dst_mac | input | 48 | Global format destination address |
| g_src_mac | input | 48 | Global format source address |
| g_ethtype | input | 16 | Global format EtherType |
| g_opcode | input | 16 | Global format opcode |
| g_quanta | input | 16 | Global format quanta |
| p_dst_mac | input | 48 | Priority format destination address |
| p_src_mac | input | 48 | Priority format source address |
| p_ethtype | input | 16 | Priority format EtherType |
| p_opcode | input | 16 | Priority format opcode |
| p_quanta | input | 128 | Per-class quanta, class c at bits 16c+15:16c |
| m_tdata | output | 8 | Frame byte |
| m_tvalid | output | 1 | Byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Final byte of the frame |

## Verification
The assertions assume that the configuration inputs stay constant while `busy` is high. The block reads them live through the whole frame instead of taking a copy, so the stall-hold property depends on that. The stimulus changes addresses, EtherTypes, opcodes and quanta only while the block is idle, before each start command. It varies only the command inputs during a frame, and it does so on purpose, to show that they are ignored. The ready line is driven at random with several stall rates, and it is always changed half a cycle away from the sampling edge.

// File: rtl/pause_pkg.sv
package pause_pkg;

   typedef enum logic {
      FMT_PRIORITY = 1'b0,
      FMT_GLOBAL   = 1'b1
   } pause_fmt_e;

   localparam int MAC_W      = 48;
   localparam int FIELD16_W  = 16;
   localparam int HDR_BYTES  = 16;
   localparam int ENVEC_W    = 16;
   localparam int FCS_BYTES  = 4;
   localparam int CRC_W      = 32;
   localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

endpackage

// File: rtl/pause_crc_byte.sv
module pause_crc_byte #(
   parameter int                 CRC_W = 32,
   parameter logic [CRC_W-1:0]   POLY  = 32'hEDB8_8320
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [7:0]       byte_in,
   output logic [CRC_W-1:0] crc_out
);

   // one reflected shift stage per data bit, lsb of the byte first
   logic [CRC_W-1:0] stage [0:8];

   assign stage[0] = crc_in;

   for (genvar g = 0; g < 8; g++) begin : g_bit
      logic fb;
      assign fb = stage[g][0] ^ byte_in[g];
      assign stage[g+1] = (stage[g] >> 1) ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[8];

endmodule

// File: rtl/pause_frame_image.sv
module pause_frame_image
   import pause_pkg::*;
#(
   parameter int NUM_CLASSES = 8,
   parameter int QUANTA_W    = 16,
   parameter int PAY_BYTES   = 60,
   localparam int IMG_W      = PAY_BYTES * 8,
   localparam int HDR_W      = HDR_BYTES * 8,
   localparam int SLOTS_W    = NUM_CLASSES * QUANTA_W,
   localparam int PRI_W      = HDR_W + ENVEC_W + SLOTS_W,
   localparam int GLB_W      = HDR_W + QUANTA_W
) (
   input  pause_fmt_e             fmt,
   input  logic [NUM_CLASSES-1:0] en_vec,
   input  logic [NUM_CLASSES:0]   zero_vec,
   input  logic [MAC_W-1:0]       g_dst_mac,
   input  logic [MAC_W-1:0]       g_src_mac,
   input  logic [FIELD16_W-1:0]   g_ethtype,
   input  logic [FIELD16_W-1:0]   g_opcode,
   input  logic [QUANTA_W-1:0]    g_quanta,
   input  logic [MAC_W-1:0]       p_dst_mac,
   input  logic [MAC_W-1:0]       p_src_mac,
   input  logic [FIELD16_W-1:0]   p_ethtype,
   input  logic [FIELD16_W-1:0]   p_opcode,
   input  logic [SLOTS_W-1:0]     p_quanta,
   output logic [IMG_W-1:0]       image
);

   logic [SLOTS_W-1:0]  slots;
   logic [ENVEC_W-1:0]  en16;
   logic [QUANTA_W-1:0] glb_q;

   // class 0 occupies the most significant slot so it leaves first
   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_slot
      assign slots[(NUM_CLASSES-1-c)*QUANTA_W +: QUANTA_W] =
         (en_vec[c] && !zero_vec[c]) ? p_quanta[c*QUANTA_W +: QUANTA_W] : '0;
   end

   assign glb_q = zero_vec[NUM_CLASSES] ? '0 : g_quanta;

   always_comb begin
      en16 = '0;
      en16[NUM_CLASSES-1:0] = en_vec;
   end

   always_comb begin
      image = '0;
      if (fmt == FMT_GLOBAL) begin
         image[IMG_W-1 -: GLB_W] = {g_dst_mac, g_src_mac, g_ethtype, g_opcode, glb_q};
      end else begin
         image[IMG_W-1 -: PRI_W] = {p_dst_mac, p_src_mac, p_ethtype, p_opcode, en16, slots};
      end
   end

endmodule

// File: rtl/pause_seq.sv
module pause_seq
   import pause_pkg::*;
#(
   parameter int FRAME_BYTES = 64,
   parameter int NUM_CLASSES = 8,
   localparam int PAY_BYTES  = FRAME_BYTES - FCS_BYTES,
   localparam int IDX_W      = $clog2(FRAME_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic                   go_global,
   input  logic [NUM_CLASSES-1:0] go_classes,
   input  logic [NUM_CLASSES:0]   go_cancel,
   input  logic                   m_tready,
   input  logic [7:0]             pay_byte,
   input  logic [CRC_W-1:0]       crc_next,
   output logic                   busy,
   output logic [IDX_W-1:0]       idx,
   output logic [CRC_W-1:0]       crc_q,
   output pause_fmt_e             fmt_q,
   output logic [NUM_CLASSES-1:0] en_q,
   output logic [NUM_CLASSES:0]   zero_q,
   output logic [7:0]             m_tdata,
   output logic                   m_tvalid,
   output logic                   m_tlast
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
   localparam logic [IDX_W-1:0] PAY_IDX  = IDX_W'(PAY_BYTES);

   logic             beat;
   logic             in_pay;
   logic [IDX_W-1:0] fcs_off;
   logic [CRC_W-1:0] fcs_sh;

   assign beat   = busy && m_tready;
   assign in_pay = idx < PAY_IDX;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         crc_q  <= CRC_SEED;
         fmt_q  <= FMT_PRIORITY;
         en_q   <= '0;
         zero_q <= '0;
      end else if (!busy) begin
         if (go) begin
            busy   <= 1'b1;
            idx    <= '0;
            crc_q  <= CRC_SEED;
            fmt_q  <= go_global ? FMT_GLOBAL : FMT_PRIORITY;
            en_q   <= go_classes | go_cancel[NUM_CLASSES-1:0];
            zero_q <= go_cancel;
         end
      end else if (beat) begin
         if (in_pay) begin
            crc_q <= crc_next;
         end
         if (idx == LAST_IDX) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // check sequence leaves inverted, least significant byte first
   assign fcs_off = idx - PAY_IDX;
   assign fcs_sh  = ~crc_q >> {fcs_off[1:0], 3'b000};

   assign m_tdata  = in_pay ? pay_byte : fcs_sh[7:0];
   assign m_tvalid = busy;
   assign m_tlast  = busy && (idx == LAST_IDX);

endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx
   import pause_pkg::*;
#(
   parameter int               NUM_CLASSES = 8,
   parameter int               QUANTA_W    = 16,
   parameter int               FRAME_BYTES = 64,
   parameter logic [31:0]      CRC_POLY    = 32'hEDB8_8320,
   localparam int              PAY_BYTES   = FRAME_BYTES - FCS_BYTES,
   localparam int              IDX_W       = $clog2(FRAME_BYTES),
   localparam int              PRI_BYTES   = HDR_BYTES + ENVEC_W/8 + NUM_CLASSES*QUANTA_W/8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            go,
   input  logic                            go_global,
   input  logic [NUM_CLASSES-1:0]          go_classes,
   input  logic [NUM_CLASSES:0]            go_cancel,
   output logic                            busy,
   input  logic [47:0]                     g_dst_mac,
   input  logic [47:0]                     g_src_mac,
   input  logic [15:0]                     g_ethtype,
   input  logic [15:0]                     g_opcode,
   input  logic [QUANTA_W-1:0]             g_quanta,
   input  logic [47:0]                     p_dst_mac,
   input  logic [47:0]                     p_src_mac,
   input  logic [15:0]                     p_ethtype,
   input  logic [15:0]                     p_opcode,
   input  logic [NUM_CLASSES*QUANTA_W-1:0] p_quanta,
   output logic [7:0]                      m_tdata,
   output logic                            m_tvalid,
   input  logic                            m_tready,
   output logic                            m_tlast
);

   // elaboration-time parameter checks
   if (NUM_CLASSES < 1 || NUM_CLASSES > ENVEC_W) begin : g_bad_classes
      $error("pause_frame_tx: NUM_CLASSES must lie in 1..16");
   end
   if (QUANTA_W % 8 != 0 || QUANTA_W < 8) begin : g_bad_quanta
      $error("pause_frame_tx: QUANTA_W must be a whole number of bytes");
   end
   if (PRI_BYTES > PAY_BYTES) begin : g_bad_frame
      $error("pause_frame_tx: FRAME_BYTES too small for the priority format");
   end

   logic [IDX_W-1:0]       idx;
   logic [CRC_W-1:0]       crc_q;
   logic [CRC_W-1:0]       crc_next;
   pause_fmt_e             fmt_q;
   logic [NUM_CLASSES-1:0] en_q;
   logic [NUM_CLASSES:0]   zero_q;
   logic [PAY_BYTES*8-1:0] image;
   logic [IDX_W-1:0]       pidx;
   logic [7:0]             pay_byte;

   pause_frame_image #(
      .NUM_CLASSES (NUM_CLASSES),
      .QUANTA_W    (QUANTA_W),
      .PAY_BYTES   (PAY_BYTES)
   ) u_image (
      .fmt       (fmt_q),
      .en_vec    (en_q),
      .zero_vec  (zero_q),
      .g_dst_mac (g_dst_mac),
      .g_src_mac (g_src_mac),
      .g_ethtype (g_ethtype),
      .g_opcode  (g_opcode),
      .g_quanta  (g_quanta),
      .p_dst_mac (p_dst_mac),
      .p_src_mac (p_src_mac),
      .p_ethtype (p_ethtype),
      .p_opcode  (p_opcode),
      .p_quanta  (p_quanta),
      .image     (image)
   );

   // byte 0 is the most significant byte of the image
   assign pidx     = (idx < IDX_W'(PAY_BYTES)) ? idx : '0;
   assign pay_byte = image[(PAY_BYTES-1-int'(pidx))*8 +: 8];

   pause_crc_byte #(
      .CRC_W (CRC_W),
      .POLY  (CRC_POLY)
   ) u_crc (
      .crc_in  (crc_q),
      .byte_in (pay_byte),
      .crc_out (crc_next)
   );

   pause_seq #(
      .FRAME_BYTES (FRAME_BYTES),
      .NUM_CLASSES (NUM_CLASSES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .go_global  (go_global),
      .go_classes (go_classes),
      .go_cancel  (go_cancel),
      .m_tready   (m_tready),
      .pay_byte   (pay_byte),
      .crc_next   (crc_next),
      .busy       (busy),
      .idx        (idx),
      .crc_q      (crc_q),
      .fmt_q      (fmt_q),
      .en_q       (en_q),
      .zero_q     (zero_q),
      .m_tdata    (m_tdata),
      .m_tvalid   (m_tvalid),
      .m_tlast    (m_tlast)
   );

endmodule

// File: rtl/pause_frame_tx_chk.sv
module pause_frame_tx_chk #(
   parameter int NUM_CLASSES = 8,
   parameter int QUANTA_W    = 16,
   parameter int FRAME_BYTES = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       go,
   input logic       go_global,
   input logic       busy,
   input logic [7:0] m_tdata,
   input logic       m_tvalid,
   input logic       m_tready,
   input logic       m_tlast
);

   localparam int PAY_BYTES = FRAME_BYTES - 4;
   localparam int GLB_END   = 18;
   localparam int PRI_END   = 18 + NUM_CLASSES * QUANTA_W / 8;

   int   beats;
   logic glob_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beats  <= 0;
         glob_q <= 1'b0;
      end else begin
         if (!busy && go) begin
            glob_q <= go_global;
         end
         if (m_tvalid && m_tready) begin
            beats <= m_tlast ? 0 : beats + 1;
         end
      end
   end

   p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go) |=> busy);

   p_last_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tlast) |-> (beats == FRAME_BYTES - 1));

   p_go_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(m_tvalid && m_tready && m_tlast)) |=> busy);

   p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && beats >= (glob_q ? GLB_END : PRI_END) && beats < PAY_BYTES)
         |-> (m_tdata == 8'h00));

   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

   p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tready && m_tlast) |=> !busy);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!m_tvalid && !m_tlast));

endmodule

bind pause_frame_tx pause_frame_tx_chk #(
   .NUM_CLASSES (NUM_CLASSES),
   .QUANTA_W    (QUANTA_W),
   .FRAME_BYTES (FRAME_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .go        (go),
   .go_global (go_global),
   .busy      (busy),
   .m_tdata   (m_tdata),
   .m_tvalid  (m_tvalid),
   .m_tready  (m_tready),
   .m_tlast   (m_tlast)
);

// File: tb/pause_frame_tx_tb.sv
`timescale 1ns/1ps
module pause_frame_tx_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         go = 1'b0;
   logic         go_global = 1'b0;
   logic [7:0]   go_classes = '0;
   logic [8:0]   go_cancel = '0;
   logic         busy;
   logic [47:0]  g_dst_mac = '0, g_src_mac = '0, p_dst_mac = '0, p_src_mac = '0;
   logic [15:0]  g_ethtype = '0, g_opcode = '0, g_quanta = '0, p_ethtype = '0, p_opcode = '0;
   logic [127:0] p_quanta = '0;
   logic [7:0]   m_tdata;
   logic         m_tvalid;
   logic         m_tready = 1'b0;
   logic         m_tlast;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   logic [7:0] exp_b [0:63];
   logic [7:0] act_b [0:63];

   always #2 clk = ~clk;

   pause_frame_tx u_dut (
      .clk (clk), .rst_n (rst_n), .go (go), .go_global (go_global),
      .go_classes (go_classes), .go_cancel (go_cancel), .busy (busy),
      .g_dst_mac (g_dst_mac), .g_src_mac (g_src_mac), .g_ethtype (g_ethtype),
      .g_opcode (g_opcode), .g_quanta (g_quanta),
      .p_dst_mac (p_dst_mac), .p_src_mac (p_src_mac), .p_ethtype (p_ethtype),
      .p_opcode (p_opcode), .p_quanta (p_quanta),
      .m_tdata (m_tdata), .m_tvalid (m_tvalid), .m_tready (m_tready), .m_tlast (m_tlast)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic put_field(input int pos, input int nbytes, input logic [47:0] val);
      for (int k = 0; k < nbytes; k++) exp_b[pos+k] = val[(nbytes-1-k)*8 +: 8];
   endtask

   // expected frame from the requirements (R4..R8)
   task automatic build_expected(input bit glob, input logic [7:0] cls, input logic [8:0] cxl);
      logic [7:0]  en;
      logic [31:0] c;
      for (int k = 0; k < 64; k++) exp_b[k] = 8'h00;
      en = cls | cxl[7:0];
      if (glob) begin
         put_field(0, 6, g_dst_mac);  put_field(6, 6, g_src_mac);
         put_field(12, 2, {32'h0, g_ethtype}); put_field(14, 2, {32'h0, g_opcode});
         put_field(16, 2, {32'h0, cxl[8] ? 16'h0 : g_quanta});
      end else begin
         put_field(0, 6, p_dst_mac);  put_field(6, 6, p_src_mac);
         put_field(12, 2, {32'h0, p_ethtype}); put_field(14, 2, {32'h0, p_opcode});
         exp_b[17] = en;
         for (int q = 0; q < 8; q++)
            if (en[q] && !cxl[q]) put_field(18 + 2*q, 2, {32'h0, p_quanta[q*16 +: 16]});
      end
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < 60; k++) begin
         c = c ^ {24'h0, exp_b[k]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      c = ~c;
      for (int k = 0; k < 4; k++) exp_b[60+k] = c[k*8 +: 8];
   endtask

   task automatic cmp_range(input int lo, input int hi, input string req);
      int bad = -1;
      for (int k = lo; k <= hi; k++) if (bad < 0 && act_b[k] !== exp_b[k]) bad = k;
      if (bad < 0) check(1'b1, req, 0, 0);
      else check(1'b0, $sformatf("%s byte %0d", req, bad), act_b[bad], exp_b[bad]);
   endtask

   task automatic randomize_cfg();
      g_dst_mac = {$urandom, $urandom}; g_src_mac = {$urandom, $urandom};
      p_dst_mac = {$urandom, $urandom}; p_src_mac = {$urandom, $urandom};
      g_ethtype = 16'($urandom); g_opcode = 16'($urandom); g_quanta = 16'(($urandom % 65535) + 1);
      p_ethtype = 16'($urandom); p_opcode = 16'($urandom);
      for (int q = 0; q < 8; q++) p_quanta[q*16 +: 16] = 16'(($urandom % 65535) + 1);
   endtask

   // called at a negedge with busy low; returns at the negedge after the last beat
   task automatic run_frame(input bit glob, input logic [7:0] cls, input logic [8:0] cxl,
                            input int stall_pct, input bit inject);
      int  got = 0, last_at = -1, guard = 0, tlast_cnt = 0;
      bit  stalled = 1'b0, hold_ok = 1'b1, injected = 1'b0;
      logic [7:0] held = '0;
      build_expected(glob, cls, cxl);
      go = 1'b1; go_global = glob; go_classes = cls; go_cancel = cxl; m_tready = 1'b0;
      @(negedge clk);
      go = 1'b0;
      check(busy === 1'b1, "R2 busy after go", busy, 1);
      while (got < 64 && guard < 5000) begin
         guard++;
         m_tready = (($urandom % 100) >= stall_pct);
         if (inject && !injected && got == 10) begin
            go = 1'b1; go_global = ~glob; go_classes = ~cls; go_cancel = ~cxl; injected = 1'b1;
         end else begin
            go = 1'b0;
         end
         #1;
         if (stalled && m_tdata !== held) hold_ok = 1'b0;
         stalled = 1'b0;
         if (m_tvalid && m_tready) begin
            act_b[got] = m_tdata;
            if (m_tlast) begin last_at = got; tlast_cnt++; end
            got++;
         end else if (m_tvalid) begin
            stalled = 1'b1; held = m_tdata;
         end
         @(negedge clk);
      end
      go = 1'b0; m_tready = 1'b0;
      check(got == 64 && last_at == 63 && tlast_cnt == 1, "R2 length and tlast", last_at, 63);
      check(busy === 1'b0 && m_tvalid === 1'b0, "R10 busy falls after last byte", busy, 0);
      cmp_range(0, 15, glob ? "R4 header" : "R5 header");
      if (cxl != 0) cmp_range(16, glob ? 17 : 33, "R6 quanta body");
      else cmp_range(16, glob ? 17 : 33, glob ? "R4 quanta" : "R5 enable and quanta");
      cmp_range(glob ? 18 : 34, 59, "R7 padding");
      cmp_range(60, 63, "R8 fcs");
      if (stall_pct > 0) check(hold_ok, "R9 hold under stall", hold_ok, 1);
      if (inject) cmp_range(0, 63, "R3 go while busy ignored");
      go_global = glob; go_classes = cls; go_cancel = cxl;
   endtask

   initial begin : watchdog
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000 && !done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && m_tvalid === 1'b0 && m_tlast === 1'b0, "R1 idle in reset", m_tvalid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy === 1'b0 && m_tvalid === 1'b0 && m_tlast === 1'b0, "R1 idle after reset", busy, 0);

      randomize_cfg();
      run_frame(1'b1, 8'h00, 9'h000, 0, 1'b0);              // R4 plain global
      randomize_cfg();
      run_frame(1'b0, 8'hA5, 9'h003, 0, 1'b0);              // R5 R6 mixed request/cancel
      randomize_cfg();
      run_frame(1'b1, 8'h00, 9'h100, 30, 1'b0);             // R6 global cancel, stalls
      randomize_cfg();
      run_frame(1'b0, 8'hFF, 9'h000, 50, 1'b0);             // R5 all classes
      randomize_cfg();
      run_frame(1'b0, 8'h00, 9'h080, 0, 1'b0);              // R6 cancel only class 7
      randomize_cfg();
      run_frame(1'b0, 8'h3C, 9'h000, 20, 1'b1);             // R3 injected go
      // R10 back to back: next go at the negedge busy is seen low
      run_frame(1'b1, 8'h00, 9'h000, 0, 1'b0);
      run_frame(1'b0, 8'h01, 9'h000, 0, 1'b0);
      repeat (3) begin
         @(negedge clk);
         check(m_tvalid === 1'b0 && busy === 1'b0, "R3 no extra frame", m_tvalid, 0);
      end

      for (int i = 0; i < 20; i++) begin
         randomize_cfg();
         run_frame(1'($urandom), 8'($urandom), 9'($urandom % 4 == 0 ? $urandom : 0),
                   int'($urandom % 70), 1'($urandom % 3 == 0));
         repeat (int'($urandom % 3)) @(negedge clk);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule